// File: doc/BRIEF.md
# DDR2/DDR3 Power-Up Initialisation Sequencer

This block walks an external DDR2 or DDR3 SDRAM through its power-up initialisation. It starts from a one-cycle start pulse. A type input selects which of two fixed command orders is used. The DDR2 order includes two auto-refresh commands and a pair of output-driver calibration steps. The DDR3 order includes an impedance (ZQ) calibration step. Both orders come from a single state machine that steps through a small command table.

The block places each command on a valid/ready port and holds it there until the command is accepted. Only one command is in flight at a time. The settling pauses are counted in clock cycles. Each pause is set in microseconds and converted to cycles at elaboration time, using a clock-frequency parameter. Mode-register commands name their target register by the bank number. The sequencer places that bank number on the address bus at a bit position it computes from the column width, row width, address-decode mode and data-bus width. These settings are captured when start is accepted.

When the final normal-mode command is accepted, the sequencer raises a done flag. That flag stays high until the next reset.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: After a synchronous reset, `cmd_valid`, `busy` and `init_done` are all low.
- R2: The bank bit position is `col + 9`, plus `row + 11` when `cfg_interleave` is 0 (sequential decode), plus 2 when `cfg_wide_bus` is 1 or 1 when it is 0.
- R3: `cmd_addr` equals `cmd_bank` shifted left by the R2 position. Extended mode-register commands carry bank 2, 3 or 1. All other commands carry bank 0 and address 0.
- R4: With `mem_ddr3`=0, the accepted commands are, in order: NOP, NOP, PRE_ALL, EMRS(2), EMRS(3), EMRS(1), MRS, PRE_ALL, REF, REF, MRS, EMRS(1), EMRS(1), NORMAL. The opcodes on `cmd_op` are NOP=0, PRE_ALL=1, MRS=2, EMRS=3, REF=4, ZQCAL=5, NORMAL=6.
- R5: With `mem_ddr3`=1, the accepted commands are, in order: NOP, NOP, EMRS(2), EMRS(3), EMRS(1), MRS, ZQCAL, NORMAL.
- R6: Between the two NOPs there is a pause of N = PWR_US × CLK_MHZ cycles, with PWR_US being 200 for DDR2 and 500 for DDR3. DDR3 also pauses N = 50 × CLK_MHZ cycles between the MRS and ZQCAL. A paused gap shows exactly N+2 cycles with `cmd_valid` low between the accept and the next command.
- R7: A command is held, unchanged, while `cmd_ready` is low. An unpaused step leaves `cmd_valid` low for exactly one cycle after each accept, whatever the ready pattern.
- R8: `cmd_dll_reset` is high only on the first MRS of either flow. `cmd_ocd_default` is high only on the first of the two final DDR2 EMRS(1) commands.
- R9: `init_done` rises in the cycle after NORMAL is accepted and stays high until reset. `busy` is low while it is high.
- R10: A start pulse while busy or done has no effect. The configuration inputs are captured at the accepted start, and later changes do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the sequence (honoured only when idle) |
| mem_ddr3 | input | 1 | 0 selects the DDR2 flow, 1 selects the DDR3 flow |
| cfg_col | input | COL_W | Column-count field |
| cfg_row | input | ROW_W | Row-count field |
| cfg_interleave | input | 1 | 1 selects interleaved decode, 0 selects sequential decode |
| cfg_wide_bus | input | 1 | 1 selects a 32-bit data bus, 0 selects a 16-bit data bus |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted when high together with cmd_valid |
| cmd_op | output | 3 | Command opcode (see R4) |
| cmd_bank | output | 2 | Bank / mode-register selector |
| cmd_addr | output | ADDR_W | Address carrying the bank at the computed position |
| cmd_dll_reset | output | 1 | DLL-reset bit for the current MRS |
| cmd_ocd_default | output | 1 | Output-driver calibration default bit for the current EMRS |
| busy | output | 1 | Sequence in progress |
| init_done | output | 1 | Sequence complete (sticky) |

## Verification
The assertions assume that `cmd_ready` is a clean level that is never X after reset. They also assume that reset is held for at least one clock edge before `start` is used. The bench drives `cmd_ready` either constantly high or high one cycle in three, changing it only on the falling edge, and releases reset before any start pulse. The configuration inputs are deliberately changed, and start is pulsed again, while a sequence is running. The bench sweeps every combination of column field, row field, decode mode and bus width for both flows, and computes the bit position arithmetically.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_PRE_ALL = 3'd1,
      OP_MRS     = 3'd2,
      OP_EMRS    = 3'd3,
      OP_REF     = 3'd4,
      OP_ZQCAL   = 3'd5,
      OP_NORMAL  = 3'd6
   } op_e;

   typedef enum logic [1:0] {
      WT_NONE     = 2'd0,
      WT_PWR_DDR2 = 2'd1,
      WT_PWR_DDR3 = 2'd2,
      WT_DLL      = 2'd3
   } wait_e;

   typedef struct packed {
      op_e        op;
      logic [1:0] bank;
      logic       dll_rst;
      logic       ocd_dflt;
      wait_e      wsel;
      logic       last;
   } step_t;

   localparam int STEP_IDX_W = 4;

endpackage

// File: rtl/ddr_bank_offset.sv
module ddr_bank_offset #(
   parameter int COL_W    = 2,
   parameter int ROW_W    = 2,
   parameter int OFF_W    = 5,
   parameter int COL_BASE = 9,
   parameter int ROW_BASE = 11
) (
   input  logic [COL_W-1:0] col,
   input  logic [ROW_W-1:0] row,
   input  logic             interleave,
   input  logic             wide_bus,
   output logic [OFF_W-1:0] offset
);
   localparam int MAX_OFF = (2**COL_W - 1) + COL_BASE + (2**ROW_W - 1) + ROW_BASE + 2;

   generate
      if (MAX_OFF >= 2**OFF_W) begin : g_bad_off_w
         $error("ddr_bank_offset: OFF_W too narrow for the largest offset");
      end
      if (COL_W < 1 || ROW_W < 1) begin : g_bad_fields
         $error("ddr_bank_offset: field widths must be positive");
      end
   endgenerate

   logic [OFF_W-1:0] col_term;
   logic [OFF_W-1:0] row_term;
   logic [OFF_W-1:0] bus_term;

   always_comb begin
      col_term = OFF_W'(col) + OFF_W'(COL_BASE);
      row_term = interleave ? '0 : (OFF_W'(row) + OFF_W'(ROW_BASE));
      bus_term = wide_bus ? OFF_W'(2) : OFF_W'(1);
      offset   = col_term + row_term + bus_term;
   end

endmodule

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired,
   output logic             running
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("ddr_wait_timer: CNT_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = run_q && (cnt_q == '0);
   assign running = run_q;

   // R6: a running count that has not reached zero keeps running
   p_count_holds_r6: assert property (@(posedge clk) disable iff (rst)
      (run_q && !expired && !load) |=> run_q);

   // R6: a pause ends exactly one cycle after it expires
   p_expire_stops_r6: assert property (@(posedge clk) disable iff (rst)
      (expired && !load) |=> !run_q);

endmodule

// File: rtl/ddr_pwrup_steps.sv
module ddr_pwrup_steps
   import ddr_pwrup_pkg::*;
#(
   parameter int IDX_W = STEP_IDX_W
) (
   input  logic             mem_ddr3,
   input  logic [IDX_W-1:0] idx,
   output step_t            step
);
   generate
      if (IDX_W < 4) begin : g_bad_idx_w
         $error("ddr_pwrup_steps: IDX_W must hold 15 steps");
      end
   endgenerate

   function automatic step_t mk_cmd(op_e o, logic [1:0] b, logic d, logic oc, logic l);
      step_t s;
      s.op       = o;
      s.bank     = b;
      s.dll_rst  = d;
      s.ocd_dflt = oc;
      s.wsel     = WT_NONE;
      s.last     = l;
      return s;
   endfunction

   function automatic step_t mk_pause(wait_e w);
      step_t s;
      s.op       = OP_NOP;
      s.bank     = 2'd0;
      s.dll_rst  = 1'b0;
      s.ocd_dflt = 1'b0;
      s.wsel     = w;
      s.last     = 1'b0;
      return s;
   endfunction

   step_t ddr2_step;
   step_t ddr3_step;

   always_comb begin
      case (idx)
         IDX_W'(0):  ddr2_step = mk_cmd(OP_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(1):  ddr2_step = mk_pause(WT_PWR_DDR2);
         IDX_W'(2):  ddr2_step = mk_cmd(OP_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(3):  ddr2_step = mk_cmd(OP_PRE_ALL, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(4):  ddr2_step = mk_cmd(OP_EMRS, 2'd2, 1'b0, 1'b0, 1'b0);
         IDX_W'(5):  ddr2_step = mk_cmd(OP_EMRS, 2'd3, 1'b0, 1'b0, 1'b0);
         IDX_W'(6):  ddr2_step = mk_cmd(OP_EMRS, 2'd1, 1'b0, 1'b0, 1'b0);
         IDX_W'(7):  ddr2_step = mk_cmd(OP_MRS, 2'd0, 1'b1, 1'b0, 1'b0);
         IDX_W'(8):  ddr2_step = mk_cmd(OP_PRE_ALL, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(9):  ddr2_step = mk_cmd(OP_REF, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(10): ddr2_step = mk_cmd(OP_REF, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(11): ddr2_step = mk_cmd(OP_MRS, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(12): ddr2_step = mk_cmd(OP_EMRS, 2'd1, 1'b0, 1'b1, 1'b0);
         IDX_W'(13): ddr2_step = mk_cmd(OP_EMRS, 2'd1, 1'b0, 1'b0, 1'b0);
         default:    ddr2_step = mk_cmd(OP_NORMAL, 2'd0, 1'b0, 1'b0, 1'b1);
      endcase
   end

   always_comb begin
      case (idx)
         IDX_W'(0): ddr3_step = mk_cmd(OP_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(1): ddr3_step = mk_pause(WT_PWR_DDR3);
         IDX_W'(2): ddr3_step = mk_cmd(OP_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
         IDX_W'(3): ddr3_step = mk_cmd(OP_EMRS, 2'd2, 1'b0, 1'b0, 1'b0);
         IDX_W'(4): ddr3_step = mk_cmd(OP_EMRS, 2'd3, 1'b0, 1'b0, 1'b0);
         IDX_W'(5): ddr3_step = mk_cmd(OP_EMRS, 2'd1, 1'b0, 1'b0, 1'b0);
         IDX_W'(6): ddr3_step = mk_cmd(OP_MRS, 2'd0, 1'b1, 1'b0, 1'b0);
         IDX_W'(7): ddr3_step = mk_pause(WT_DLL);
         IDX_W'(8): ddr3_step = mk_cmd(OP_ZQCAL, 2'd0, 1'b0, 1'b0, 1'b0);
         default:   ddr3_step = mk_cmd(OP_NORMAL, 2'd0, 1'b0, 1'b0, 1'b1);
      endcase
   end

   assign step = mem_ddr3 ? ddr3_step : ddr2_step;

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
   import ddr_pwrup_pkg::*;
#(
   parameter int CLK_MHZ     = 200,
   parameter int DDR2_PWR_US = 200,
   parameter int DDR3_PWR_US = 500,
   parameter int DLL_US      = 50,
   parameter int COL_W       = 2,
   parameter int ROW_W       = 2,
   parameter int ADDR_W      = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              mem_ddr3,
   input  logic [COL_W-1:0]  cfg_col,
   input  logic [ROW_W-1:0]  cfg_row,
   input  logic              cfg_interleave,
   input  logic              cfg_wide_bus,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [2:0]        cmd_op,
   output logic [1:0]        cmd_bank,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_dll_reset,
   output logic              cmd_ocd_default,
   output logic              busy,
   output logic              init_done
);
   localparam int DDR2_CYC = DDR2_PWR_US * CLK_MHZ;
   localparam int DDR3_CYC = DDR3_PWR_US * CLK_MHZ;
   localparam int DLL_CYC  = DLL_US * CLK_MHZ;
   localparam int MAX_CYC  = (DDR2_CYC > DDR3_CYC) ?
                             ((DDR2_CYC > DLL_CYC) ? DDR2_CYC : DLL_CYC) :
                             ((DDR3_CYC > DLL_CYC) ? DDR3_CYC : DLL_CYC);
   localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam int OFF_W    = $clog2(ADDR_W);
   localparam int MAX_OFF  = (2**COL_W - 1) + 9 + (2**ROW_W - 1) + 11 + 2;

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("ddr_pwrup_seq: CLK_MHZ must be at least 1");
      end
      if (DDR2_CYC < 1 || DDR3_CYC < 1 || DLL_CYC < 1) begin : g_bad_pause
         $error("ddr_pwrup_seq: every pause must last at least one cycle");
      end
      if (ADDR_W < MAX_OFF + 2) begin : g_bad_addr_w
         $error("ddr_pwrup_seq: ADDR_W cannot hold a bank at the largest offset");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_STEP = 3'd1,
      S_CMD  = 3'd2,
      S_WAIT = 3'd3,
      S_DONE = 3'd4
   } state_e;

   state_e                state_q;
   logic [STEP_IDX_W-1:0] idx_q;
   logic                  ddr3_q;
   logic [COL_W-1:0]      col_q;
   logic [ROW_W-1:0]      row_q;
   logic                  inter_q;
   logic                  wide_q;

   step_t                 step;
   logic [OFF_W-1:0]      bank_pos;
   logic                  t_load;
   logic [CNT_W-1:0]      t_val;
   logic                  t_expired;
   logic                  t_running;
   logic                  accept;

   ddr_pwrup_steps #(.IDX_W(STEP_IDX_W)) u_steps (
      .mem_ddr3 (ddr3_q),
      .idx      (idx_q),
      .step     (step)
   );

   ddr_bank_offset #(
      .COL_W    (COL_W),
      .ROW_W    (ROW_W),
      .OFF_W    (OFF_W),
      .COL_BASE (9),
      .ROW_BASE (11)
   ) u_offset (
      .col        (col_q),
      .row        (row_q),
      .interleave (inter_q),
      .wide_bus   (wide_q),
      .offset     (bank_pos)
   );

   always_comb begin
      case (step.wsel)
         WT_PWR_DDR2: t_val = CNT_W'(DDR2_CYC - 1);
         WT_PWR_DDR3: t_val = CNT_W'(DDR3_CYC - 1);
         WT_DLL:      t_val = CNT_W'(DLL_CYC - 1);
         default:     t_val = '0;
      endcase
   end

   assign t_load = (state_q == S_STEP) && (step.wsel != WT_NONE);

   ddr_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired),
      .running  (t_running)
   );

   assign accept = (state_q == S_CMD) && cmd_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         ddr3_q  <= 1'b0;
         col_q   <= '0;
         row_q   <= '0;
         inter_q <= 1'b0;
         wide_q  <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: if (start) begin
               state_q <= S_STEP;
               idx_q   <= '0;
               ddr3_q  <= mem_ddr3;
               col_q   <= cfg_col;
               row_q   <= cfg_row;
               inter_q <= cfg_interleave;
               wide_q  <= cfg_wide_bus;
            end
            S_STEP: state_q <= (step.wsel != WT_NONE) ? S_WAIT : S_CMD;
            S_CMD: if (cmd_ready) begin
               if (step.last) state_q <= S_DONE;
               else begin
                  state_q <= S_STEP;
                  idx_q   <= idx_q + 1'b1;
               end
            end
            S_WAIT: if (t_expired) begin
               state_q <= S_STEP;
               idx_q   <= idx_q + 1'b1;
            end
            default: state_q <= S_DONE;
         endcase
      end
   end

   logic [ADDR_W-1:0] bank_ext;
   assign bank_ext = {{(ADDR_W-2){1'b0}}, step.bank};

   always_comb begin
      cmd_valid       = (state_q == S_CMD);
      cmd_op          = cmd_valid ? step.op : OP_NOP;
      cmd_bank        = cmd_valid ? step.bank : 2'd0;
      cmd_addr        = cmd_valid ? (bank_ext << bank_pos) : '0;
      cmd_dll_reset   = cmd_valid && step.dll_rst;
      cmd_ocd_default = cmd_valid && step.ocd_dflt;
      busy            = (state_q == S_STEP) || (state_q == S_CMD) || (state_q == S_WAIT);
      init_done       = (state_q == S_DONE);
   end

   // R7: a stalled command is held unchanged
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
                                     $stable(cmd_bank) && $stable(cmd_addr)));

   // R7: one command at a time, valid drops after each accept
   p_one_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_ready) |=> !cmd_valid);

   // R9: done is sticky until reset
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // R9: done follows the acceptance of the normal-mode command
   p_done_after_normal_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(init_done) |-> $past(cmd_valid && cmd_ready && (cmd_op == 3'd6)));

   // R3: every extended mode-register command names a non-zero bank
   p_emrs_bank_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && (cmd_op == 3'd3)) |-> (cmd_bank != 2'd0));

   // R10: no command appears outside a running sequence
   p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !cmd_valid);

   // R6: no command is presented while a pause is counting
   p_no_cmd_in_pause_r6: assert property (@(posedge clk) disable iff (rst)
      t_running |-> !cmd_valid);

   // R10: a start during a run does not disturb the pending command
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
      (start && cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)));

   // R8: calibration-default and DLL-reset flags are never set together
   p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
      !(cmd_dll_reset && cmd_ocd_default));

   logic unused_accept;
   assign unused_accept = accept;

endmodule

// File: tb/ddr_pwrup_seq_tb.sv
module ddr_pwrup_seq_tb;
   localparam int CLK_MHZ = 1;
   localparam int ADDR_W  = 32;
   localparam int N_DDR2  = 200 * CLK_MHZ;
   localparam int N_DDR3  = 500 * CLK_MHZ;
   localparam int N_DLL   = 50 * CLK_MHZ;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic              mem_ddr3 = 1'b0;
   logic [1:0]        cfg_col = '0;
   logic [1:0]        cfg_row = '0;
   logic              cfg_interleave = 1'b0;
   logic              cfg_wide_bus = 1'b0;
   logic              cmd_valid;
   logic              cmd_ready = 1'b0;
   logic [2:0]        cmd_op;
   logic [1:0]        cmd_bank;
   logic [ADDR_W-1:0] cmd_addr;
   logic              cmd_dll_reset;
   logic              cmd_ocd_default;
   logic              busy;
   logic              init_done;

   always #2.5 clk = ~clk;

   ddr_pwrup_seq #(
      .CLK_MHZ(CLK_MHZ), .DDR2_PWR_US(200), .DDR3_PWR_US(500), .DLL_US(50),
      .COL_W(2), .ROW_W(2), .ADDR_W(ADDR_W)
   ) u_dut (
      .clk(clk), .rst(rst), .start(start), .mem_ddr3(mem_ddr3),
      .cfg_col(cfg_col), .cfg_row(cfg_row), .cfg_interleave(cfg_interleave),
      .cfg_wide_bus(cfg_wide_bus), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
      .cmd_dll_reset(cmd_dll_reset), .cmd_ocd_default(cmd_ocd_default),
      .busy(busy), .init_done(init_done)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: drives ready on falling edges and records accepted commands
   logic              stall_mode = 1'b0;
   logic              mon_clr = 1'b1;
   int                n_acc = 0;
   int                low_cnt = 0;
   int                phase = 0;
   logic [2:0]        rec_op   [32];
   logic [1:0]        rec_bank [32];
   logic [ADDR_W-1:0] rec_addr [32];
   logic              rec_dll  [32];
   logic              rec_ocd  [32];
   int                rec_gap  [32];

   always @(negedge clk) begin
      logic r;
      if (mon_clr) begin
         n_acc   = 0;
         low_cnt = 0;
         phase   = 0;
         cmd_ready <= 1'b0;
      end else begin
         phase = phase + 1;
         r = stall_mode ? ((phase % 3) == 2) : 1'b1;
         cmd_ready <= r;
         if (!cmd_valid) low_cnt = low_cnt + 1;
         else if (r) begin
            if (n_acc < 32) begin
               rec_op[n_acc]   = cmd_op;
               rec_bank[n_acc] = cmd_bank;
               rec_addr[n_acc] = cmd_addr;
               rec_dll[n_acc]  = cmd_dll_reset;
               rec_ocd[n_acc]  = cmd_ocd_default;
               rec_gap[n_acc]  = low_cnt;
            end
            n_acc   = n_acc + 1;
            low_cnt = 0;
         end
      end
   end

   // expected list
   int         exp_n;
   logic [2:0] exp_op   [32];
   logic [1:0] exp_bank [32];
   logic       exp_dll  [32];
   logic       exp_ocd  [32];
   int         exp_gap  [32];

   task automatic add(input int op, input int bank, input bit d, input bit o, input int gap);
      exp_op[exp_n]   = 3'(op);
      exp_bank[exp_n] = 2'(bank);
      exp_dll[exp_n]  = d;
      exp_ocd[exp_n]  = o;
      exp_gap[exp_n]  = gap;
      exp_n++;
   endtask

   task automatic build_exp(input bit ddr3);
      exp_n = 0;
      if (!ddr3) begin
         add(0,0,0,0,0); add(0,0,0,0,N_DDR2+2); add(1,0,0,0,1);
         add(3,2,0,0,1); add(3,3,0,0,1); add(3,1,0,0,1);
         add(2,0,1,0,1); add(1,0,0,0,1); add(4,0,0,0,1); add(4,0,0,0,1);
         add(2,0,0,0,1); add(3,1,0,1,1); add(3,1,0,0,1); add(6,0,0,0,1);
      end else begin
         add(0,0,0,0,0); add(0,0,0,0,N_DDR3+2); add(3,2,0,0,1);
         add(3,3,0,0,1); add(3,1,0,0,1); add(2,0,1,0,1);
         add(5,0,0,0,N_DLL+2); add(6,0,0,0,1);
      end
   endtask

   task automatic run_seq(input bit ddr3, input int col, input int row,
                          input bit inter, input bit wide, input bit stall);
      int off;
      int n_done;
      bit finished;
      string rq;
      rq = ddr3 ? "R5" : "R4";
      @(negedge clk);
      mon_clr = 1'b1;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      // R1: reset state
      chk(cmd_valid == 1'b0 && busy == 1'b0 && init_done == 1'b0, "R1",
          "reset outputs", {cmd_valid, busy, init_done}, 0);
      @(negedge clk);
      mem_ddr3 = ddr3; cfg_col = 2'(col); cfg_row = 2'(row);
      cfg_interleave = inter; cfg_wide_bus = wide;
      stall_mode = stall;
      mon_clr = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      // R10: change configuration and pulse start while busy
      mem_ddr3 = ~ddr3; cfg_col = ~cfg_col; cfg_row = ~cfg_row;
      cfg_interleave = ~inter; cfg_wide_bus = ~wide;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finished = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (init_done) begin finished = 1'b1; break; end
      end
      chk(finished, "R9", "sequence completes", finished, 1);
      build_exp(ddr3);
      off = col + 9 + (inter ? 0 : row + 11) + (wide ? 2 : 1);
      chk(n_acc == exp_n, rq, "command count", n_acc, exp_n);
      for (int k = 0; k < exp_n && k < n_acc; k++) begin
         chk(rec_op[k] == exp_op[k], rq, $sformatf("opcode #%0d", k), rec_op[k], exp_op[k]);
         chk(rec_bank[k] == exp_bank[k], "R3", $sformatf("bank #%0d", k), rec_bank[k], exp_bank[k]);
         chk(rec_addr[k] == (ADDR_W'(exp_bank[k]) << off), "R2",
             $sformatf("address #%0d", k), rec_addr[k], ADDR_W'(exp_bank[k]) << off);
         chk(rec_dll[k] == exp_dll[k] && rec_ocd[k] == exp_ocd[k], "R8",
             $sformatf("flags #%0d", k), {rec_dll[k], rec_ocd[k]}, {exp_dll[k], exp_ocd[k]});
         if (k > 0) begin
            if (exp_gap[k] > 1)
               chk(rec_gap[k] == exp_gap[k], "R6", $sformatf("pause gap #%0d", k), rec_gap[k], exp_gap[k]);
            else
               chk(rec_gap[k] == exp_gap[k], "R7", $sformatf("gap #%0d", k), rec_gap[k], exp_gap[k]);
         end
      end
      // R9 / R10: start after completion is ignored, done stays high
      n_done = n_acc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      chk(n_acc == n_done && !cmd_valid, "R10", "commands after done", n_acc, n_done);
      chk(init_done && !busy, "R9", "done sticky, busy low", {init_done, busy}, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      for (int t = 0; t < 2; t++)
         for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
               for (int m = 0; m < 4; m++)
                  run_seq(t[0], c, r, m[0], m[1], c[0] ^ r[0] ^ m[0]);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule